// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block guards a processor against a hung program. Software arms it by writing one 32-bit control word that carries a 9-bit count, a run command and a 7-bit key. While the watchdog is enabled, software may rewrite the control word only if the new key is the bitwise inverse of the key already stored. Because each accepted write changes the required key, a program that has run wild is unlikely to reload the watchdog by accident.

The counter moves down by one on each pulse of an external slow tick enable, nominally 760 Hz. The first time it runs out, the block raises a non-maskable interrupt and reloads a short grace count of 10 ticks. If software does not service the watchdog within that grace window, the second expiry produces a one-cycle system reset request. The block then returns to its stopped, disabled state. Acting on that request is left to the system's reset controller.

Software can read back the stored control word and a status word. The status word reports the expiry stage, whether the counter is running, and the live count.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the stored control word is 0, the counter is stopped, the stage is 0, and both `nmi` and `reset_req` are low.
- R2: When the stored run bit (bit 8) is 0, a write to offset 0x40 is accepted whatever its key (bits [15:9]). The whole written word is stored and reads back at offset 0x40.
- R3: When the stored run bit is 1, a write whose key is not the bitwise inverse of the stored key is ignored. The control readback and the live count are unchanged.
- R4: When the stored run bit is 1, a write whose key equals the bitwise inverse of the stored key is accepted. It reloads the counter from the written count field, bits [8:0].
- R5: A written count field of 0 loads 256 into the counter.
- R6: An accepted write with bit 8 set starts the counter. An accepted write with bit 8 clear stops it, and a stopped counter ignores ticks.
- R7: A running counter drops by exactly one per cycle in which `tick` is high, and holds its value in other cycles.
- R8: When a running counter at 1 receives a tick in stage 0, `nmi` rises and the stage becomes 1. The counter reloads 10 and keeps running.
- R9: When the counter runs out in stage 1, `reset_req` is high for exactly one cycle. In that same cycle the control word reads 0, the counter is stopped, the stage is 0 and `nmi` is low.
- R10: Once raised, `nmi` stays high until an accepted control write or a reset. An accepted write clears `nmi`, returns the stage to 0 and reloads the counter.
- R11: A read at offset 0x44 returns the stage in bit 0, the running flag in bit 1 and the live count in bits [24:16], with all other bits 0. A read at any other offset except 0x40 returns 0.
- R12: When an accepted write and a tick fall in the same cycle, the write wins and the counter holds the freshly loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow tick enable, one cycle high per count step |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| nmi | output | 1 | Non-maskable interrupt, held high after the first expiry |
| reset_req | output | 1 | One-cycle system reset request after the second expiry |

## Verification
The hardest state to reach from the ports is the second expiry. Getting there takes an armed watchdog, a full count of at least 256 ticks, and then the 10-tick grace window, with no accepted write anywhere in between. The stimulus arms the counter with a known key and runs it down with single-cycle tick pulses. Along the way it tries a write with an uncomplemented key, which must leave the countdown alone, then lets the grace window run out while counting how many cycles `reset_req` is high. Randomized key and count writes then exercise the rotating-key acceptance rule from many stored states, checked against a bench model of which writes are accepted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W   = 9;            // count field width, bits [CNT_W-1:0]
  localparam int RUN_BIT = CNT_W - 1;    // run command shares the top count bit
  localparam int KEY_W   = 7;
  localparam int KEY_LSB = CNT_W;        // key sits right above the count

  typedef enum logic {STG_ARMED = 1'b0, STG_GRACE = 1'b1} wd_stage_e;

  // A zero count field means the largest half-range value.
  function automatic logic [CNT_W-1:0] reload_value(input logic [CNT_W-1:0] field);
    return (field == '0) ? CNT_W'(1 << (CNT_W - 1)) : field;
  endfunction

  // The rotating key rule: open when disabled, else the inverse is required.
  function automatic logic key_accept(input logic enabled,
                                      input logic [KEY_W-1:0] old_key,
                                      input logic [KEY_W-1:0] new_key);
    return !enabled || (new_key == ~old_key);
  endfunction
endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate
  import wdog_pkg::*;
(
  input  logic        wr_sel_i,
  input  logic [31:0] stored_i,
  input  logic [31:0] wdata_i,
  output logic        accept_o
);
  logic [KEY_W-1:0] old_key;
  logic [KEY_W-1:0] new_key;

  assign old_key  = stored_i[KEY_LSB +: KEY_W];
  assign new_key  = wdata_i[KEY_LSB +: KEY_W];
  assign accept_o = wr_sel_i && key_accept(stored_i[RUN_BIT], old_key, new_key);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int GRACE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             grace_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // An accepted write masks a coincident tick (R12).
  assign expire_o  = run_q && tick_i && !load_i && (cnt_q == CNT_W'(1));
  assign cnt_o     = cnt_q;
  assign running_o = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= run_i;
    end else if (expire_o) begin
      if (!grace_i) begin
        cnt_q <= CNT_W'(GRACE);
      end else begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_tick_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && tick_i && !load_i && cnt_q > CNT_W'(1) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !load_i |=> $stable(cnt_q));
  assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !load_i |=> $stable(cnt_q) && !run_q);
  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
  assert_grace_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && !grace_i |=> cnt_q == CNT_W'(GRACE) && run_q);
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic expire_i,
  output logic grace_o,
  output logic final_o,
  output logic nmi_o,
  output logic reset_req_o
);
  wd_stage_e stage_q;
  logic      nmi_q;
  logic      rreq_q;

  assign grace_o     = (stage_q == STG_GRACE);
  assign final_o     = expire_i && grace_o;
  assign nmi_o       = nmi_q;
  assign reset_req_o = rreq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_ARMED;
      nmi_q   <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      rreq_q <= final_o;
      if (clear_i || final_o) begin
        stage_q <= STG_ARMED;
        nmi_q   <= 1'b0;
      end else if (expire_i) begin
        stage_q <= STG_GRACE;
        nmi_q   <= 1'b1;
      end
    end
  end

  assert_nmi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q && !clear_i && !final_o |=> nmi_q);
  assert_nmi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_q) |-> $past(expire_i));
  assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> !rreq_q);
  assert_clear_drops_nmi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !nmi_q && stage_q == STG_ARMED);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int         GRACE    = 10,
  parameter logic [7:0] CTRL_OFF = 8'h40,
  parameter logic [7:0] STAT_OFF = 8'h44
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        nmi,
  output logic        reset_req
);
  localparam int STAT_PAD = 32 - 16 - CNT_W;

  logic [31:0]      ctrl_q;
  logic             wr_ctrl;
  logic             accept;
  logic             expire;
  logic             grace;
  logic             final_exp;
  logic             running;
  logic [CNT_W-1:0] live_cnt;

  assign wr_ctrl = wr_en && (addr == CTRL_OFF);

  wdog_keygate u_gate (
    .wr_sel_i (wr_ctrl),
    .stored_i (ctrl_q),
    .wdata_i  (wdata),
    .accept_o (accept)
  );

  wdog_counter #(.GRACE(GRACE)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (reload_value(wdata[CNT_W-1:0])),
    .run_i      (wdata[RUN_BIT]),
    .tick_i     (tick),
    .grace_i    (grace),
    .cnt_o      (live_cnt),
    .running_o  (running),
    .expire_o   (expire)
  );

  wdog_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (accept),
    .expire_i    (expire),
    .grace_o     (grace),
    .final_o     (final_exp),
    .nmi_o       (nmi),
    .reset_req_o (reset_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (accept)    ctrl_q <= wdata;
    else if (final_exp) ctrl_q <= '0;
  end

  always_comb begin
    if (addr == CTRL_OFF)      rdata = ctrl_q;
    else if (addr == STAT_OFF) rdata = {{STAT_PAD{1'b0}}, live_cnt, 14'b0, running, grace};
    else                       rdata = '0;
  end

  assert_locked_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && ctrl_q[RUN_BIT] && wdata[KEY_LSB +: KEY_W] != ~ctrl_q[KEY_LSB +: KEY_W]
    && !final_exp |=> $stable(ctrl_q));
  assert_open_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !ctrl_q[RUN_BIT] |=> ctrl_q == $past(wdata));
  assert_reset_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ctrl_q == '0 && !running && !nmi && !grace);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nmi;
  logic        reset_req;

  int n_tests = 0;
  int n_fail  = 0;
  int rreq_cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .nmi(nmi), .reset_req(reset_req)
  );

  always @(posedge clk) if (reset_req) rreq_cycles++;

  function automatic int exp_load(input int field);
    return (field % 512 == 0) ? 256 : field % 512;
  endfunction

  function automatic bit exp_accept(input logic [31:0] stored, input logic [31:0] nw);
    if (!stored[8]) return 1'b1;
    return nw[15:9] == (~stored[15:9] & 7'h7f);
  endfunction

  function automatic logic [31:0] exp_status(input int cnt, input bit run, input bit stg);
    return (32'(cnt) << 16) | (32'(run) << 1) | 32'(stg);
  endfunction

  function automatic logic [31:0] mk(input int key, input int field);
    return (32'(key & 7'h7f) << 9) | 32'(field & 9'h1ff);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [31:0] d, input bit with_tick);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h40; wdata = d; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m_ctrl;
    int m_cnt;
    bit m_run;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h40, d); check("R1 ctrl", d, 0);
    rd(8'h44, d); check("R1 status", d, 0);
    check("R1 nmi", {31'b0, nmi}, 0);
    check("R1 reset_req", {31'b0, reset_req}, 0);

    // R2 open write, count 0x105 run
    wr(mk(7'h2A, 9'h105), 1'b0);
    rd(8'h40, d); check("R2 readback", d, mk(7'h2A, 9'h105));
    rd(8'h44, d); check("R6 R11 running status", d, exp_status(261, 1, 0));

    // R7 ticks and idle
    ticks(3);
    repeat (5) @(negedge clk);
    rd(8'h44, d); check("R7 count after 3 ticks", d, exp_status(258, 1, 0));

    // R3 wrong key ignored
    wr(mk(7'h2A, 9'h1F0), 1'b0);
    rd(8'h40, d); check("R3 ctrl unchanged", d, mk(7'h2A, 9'h105));
    rd(8'h44, d); check("R3 count unchanged", d, exp_status(258, 1, 0));

    // R4 + R12 inverse key with coincident tick
    wr(mk(7'h55, 9'h103), 1'b1);
    rd(8'h40, d); check("R4 accepted", d, mk(7'h55, 9'h103));
    rd(8'h44, d); check("R12 write beats tick", d, exp_status(259, 1, 0));

    // R8 first expiry
    ticks(258);
    check("R8 nmi before expiry", {31'b0, nmi}, 0);
    ticks(1);
    check("R8 nmi raised", {31'b0, nmi}, 1);
    rd(8'h44, d); check("R8 grace status", d, exp_status(10, 1, 1));
    repeat (20) @(negedge clk);
    check("R10 nmi held", {31'b0, nmi}, 1);

    // R9 second expiry
    ticks(9);
    check("R9 no early request", rreq_cycles, 0);
    ticks(1);
    check("R9 request high", {31'b0, reset_req}, 1);
    rd(8'h40, d); check("R9 ctrl cleared", d, 0);
    rd(8'h44, d); check("R9 status cleared", d, 0);
    check("R9 nmi low", {31'b0, nmi}, 0);
    repeat (4) @(negedge clk);
    check("R9 one-cycle pulse", rreq_cycles, 1);

    // R10 accepted write clears nmi
    wr(mk(7'h11, 9'h100), 1'b0);
    ticks(256);
    check("R10 nmi up again", {31'b0, nmi}, 1);
    wr(mk(7'h6E, 9'h104), 1'b0);
    check("R10 nmi cleared", {31'b0, nmi}, 0);
    rd(8'h44, d); check("R10 reload status", d, exp_status(260, 1, 0));

    // R5 zero count, stop (R6)
    wr(mk(7'h11, 9'h000), 1'b0);
    rd(8'h44, d); check("R5 zero loads 256", d, exp_status(256, 0, 0));
    ticks(5);
    rd(8'h44, d); check("R6 stopped ignores ticks", d, exp_status(256, 0, 0));

    // R11 other offset
    rd(8'h48, d); check("R11 other offset", d, 0);

    // R2/R3/R4 random key traffic
    m_ctrl = mk(7'h11, 9'h000); m_cnt = 256; m_run = 0;
    for (int it = 0; it < 200; it++) begin
      int key;
      int field;
      logic [31:0] w;
      key   = ($urandom % 2 == 0) ? int'(~m_ctrl[15:9] & 7'h7f) : int'($urandom % 128);
      field = $urandom % 512;
      w = mk(key, field) | ({$urandom} & 32'hFFFF0000);
      if (exp_accept(m_ctrl, w)) begin
        m_ctrl = w; m_cnt = exp_load(field); m_run = w[8];
      end
      wr(w, 1'b0);
      rd(8'h40, d); check("R3 R4 random ctrl", d, m_ctrl);
      rd(8'h44, d); check("R5 R6 random status", d, exp_status(m_cnt, m_run, 0));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule